// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Recovery

This block takes an asynchronous serial line, samples it with a 16x baud tick and rebuilds characters of five to eight data bits. Each frame may carry a parity bit, and one stop bit ends it. Every finished character goes into a four-entry receive queue together with three per-character flags: parity error, framing error and line break. The head of the queue is always visible on the read outputs. A one-cycle pop strobe removes it. A ready flag shows that the queue holds at least one entry, and a full flag shows that no more entries fit.

The receiver handles two awkward line conditions without software help. If a nonzero frame ends with a low stop bit, the character is stored with a framing error. If the line is still low half a bit after that, the low level is taken as the start of the next frame. A line held low for a whole frame produces an all-zero break entry. When a break begins in the middle of a frame, the damaged frame is stored first and the break entry follows one frame time later. After a break, the line must be high for half a bit before the receiver hunts for a start bit again.

A character that completes while the queue is full is dropped. This raises a sticky overrun flag, which only a clear strobe resets. When automatic flow control is enabled, the request-to-send output drops on overrun and rises again once the queue has room.

Top module: `serial_rx_brk`

## Requirements
- R1: Each bit is sampled once, at the middle of its 16-tick period. A falling edge starts a frame only if the line is still low 8 ticks later, so a shorter low pulse produces no entry.
- R2: The data width is 5 + `cfg_data_bits_i` (00=5 … 11=8), received LSB first and stored right-aligned with zero upper bits. `cfg_parity_i` 01 selects even parity and 10 selects odd parity. 00 or 11 means there is no parity bit. One stop bit ends the frame.
- R3: When parity is enabled and the received parity bit does not match the data (even: XOR of data and parity bit is 0; odd: that XOR is 1), the entry carries `err_parity_o`=1.
- R4: After a high stop bit, the receiver hunts for a start bit at once. A frame whose start bit follows the stop bit with no idle time is received correctly.
- R5: A frame with a low stop bit in which at least one data or parity bit was high is stored with `err_frame_o`=1. If the line is still low at the end of that stop bit, the low level is the start bit of a new frame.
- R6: A frame in which every sample, stop bit included, is low is stored as data 0 with `brk_o`=1 and `err_frame_o`=0.
- R7: After a break entry, a search for a new start bit begins only after 8 consecutive high ticks. A shorter high pulse followed by more low level adds no entry.
- R8: A break that begins mid-frame yields two entries in order: the damaged frame with `err_frame_o`=1, then a data-0 entry with `brk_o`=1, provided the line stays low through the next frame time.
- R9: The queue holds 4 entries, oldest first. `pop_i` removes the head. `rx_ready_o` means not empty, `fifo_full_o` means 4 entries are held, and all head outputs read 0 while the queue is empty.
- R10: A character that completes while the queue is full is discarded and sets `overrun_o`. The stored entries and the head are kept.
- R11: `overrun_o` stays set until `err_clr_i` is pulsed. Popping does not clear it.
- R12: With `cfg_rts_auto_i`=1, `rts_o` goes low the cycle after an overrun and goes high one cycle after the queue is no longer full. With `cfg_rts_auto_i`=0, `rts_o` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_data_bits_i | input | 2 | Data width select, width = 5 + value |
| cfg_parity_i | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_rts_auto_i | input | 1 | Enable automatic request-to-send control |
| pop_i | input | 1 | Remove the head entry |
| err_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Head entry data |
| err_parity_o | output | 1 | Head entry parity error |
| err_frame_o | output | 1 | Head entry framing error |
| brk_o | output | 1 | Head entry is a break |
| rx_ready_o | output | 1 | Queue not empty |
| fifo_full_o | output | 1 | Queue full |
| overrun_o | output | 1 | Sticky overrun flag |
| rts_o | output | 1 | Request to send, high means ready to receive |

## Verification
Some properties are checked on every cycle:
- head flags read zero when the queue is empty;
- a break entry carries zero data;
- the head and the full state hold through an overrun;
- the overrun flag persists;
- request-to-send falls after an overrun;
- a break keeps the receiver waiting while the line stays low.

Other behaviour shows only in the bench's line scenarios:
- rejection of a short glitch;
- parity results for each width and mode;
- the recovery of a new start bit after a framing error;
- the two-entry split of a mid-frame break;
- the half-bit high guard that follows a break.

The scoreboard compares each entry against values built from the frame the bench drove.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_FE_CHK,
        ST_BRK_WAIT
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_RSVD = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic              brk;
        logic              frame;
        logic              parity;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rxb_frame.sv
`timescale 1ns/1ps
module rxb_frame
    import rxb_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      rx_i,
    input  logic      tick_i,
    input  logic [1:0] cfg_bits_i,
    input  logic [1:0] cfg_par_i,
    output logic      push_o,
    output rx_entry_t entry_o
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2 - 1;
    localparam int LAST = OVS - 1;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     cnt;
        logic [2:0]        bidx;
        logic [CHAR_W-1:0] data;
        logic              par;
        logic              pe;
        logic              all_low;
    } frame_t;

    frame_t     frm_d, frm_q;
    logic [2:0] last_bit;
    logic       par_on;

    always_comb begin
        frm_d    = frm_q;
        push_o   = 1'b0;
        entry_o  = '0;
        last_bit = {1'b0, cfg_bits_i} + 3'd4;
        par_on   = (cfg_par_i == PAR_EVEN) || (cfg_par_i == PAR_ODD);
        if (tick_i) begin
            case (frm_q.st)
                ST_IDLE: begin
                    if (!rx_i) begin
                        frm_d.st  = ST_START;
                        frm_d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (frm_q.cnt == CW'(HALF)) begin
                        frm_d.cnt = '0;
                        if (!rx_i) begin
                            frm_d.st      = ST_DATA;
                            frm_d.bidx    = '0;
                            frm_d.data    = '0;
                            frm_d.par     = 1'b0;
                            frm_d.pe      = 1'b0;
                            frm_d.all_low = 1'b1;
                        end else begin
                            frm_d.st = ST_IDLE;
                        end
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (frm_q.cnt == CW'(LAST)) begin
                        frm_d.cnt              = '0;
                        frm_d.data[frm_q.bidx] = rx_i;
                        frm_d.par              = frm_q.par ^ rx_i;
                        frm_d.all_low          = frm_q.all_low & ~rx_i;
                        if (frm_q.bidx == last_bit) begin
                            frm_d.st = par_on ? ST_PARITY : ST_STOP;
                        end else begin
                            frm_d.bidx = frm_q.bidx + 1'b1;
                        end
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (frm_q.cnt == CW'(LAST)) begin
                        frm_d.cnt     = '0;
                        frm_d.pe      = (cfg_par_i == PAR_ODD) ? ~(frm_q.par ^ rx_i)
                                                               :  (frm_q.par ^ rx_i);
                        frm_d.all_low = frm_q.all_low & ~rx_i;
                        frm_d.st      = ST_STOP;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (frm_q.cnt == CW'(LAST)) begin
                        frm_d.cnt = '0;
                        push_o    = 1'b1;
                        if (rx_i) begin
                            entry_o.parity = frm_q.pe;
                            entry_o.data   = frm_q.data;
                            frm_d.st       = ST_IDLE;
                        end else if (frm_q.all_low) begin
                            entry_o.brk = 1'b1;
                            frm_d.st    = ST_BRK_WAIT;
                        end else begin
                            entry_o.frame  = 1'b1;
                            entry_o.parity = frm_q.pe;
                            entry_o.data   = frm_q.data;
                            frm_d.st       = ST_FE_CHK;
                        end
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                ST_FE_CHK: begin
                    if (frm_q.cnt == CW'(HALF)) begin
                        frm_d.cnt = '0;
                        frm_d.st  = rx_i ? ST_IDLE : ST_START;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                ST_BRK_WAIT: begin
                    if (!rx_i) begin
                        frm_d.cnt = '0;
                    end else if (frm_q.cnt == CW'(HALF)) begin
                        frm_d.cnt = '0;
                        frm_d.st  = ST_IDLE;
                    end else begin
                        frm_d.cnt = frm_q.cnt + 1'b1;
                    end
                end
                default: frm_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            frm_q <= '0;
        end else begin
            frm_q <= frm_d;
        end
    end

    // R7: a low line keeps the receiver parked after a break
    p_brk_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_q.st == ST_BRK_WAIT && !rx_i) |=> (frm_q.st == ST_BRK_WAIT));

    // R1: a frame is entered only from a start bit that was low at its midpoint
    p_start_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_q.st == ST_DATA && $past(frm_q.st) == ST_START) |-> !$past(rx_i));

endmodule

// File: rtl/rxb_fifo.sv
`timescale 1ns/1ps
module rxb_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         nempty_o,
    output logic         full_o,
    output logic         ovf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_push, do_pop;

    always_comb begin
        fifo_d  = fifo_q;
        do_pop  = pop_i && (fifo_q.cnt != '0);
        do_push = push_i && (fifo_q.cnt != CW'(DEPTH));
        if (do_push) begin
            fifo_d.mem[fifo_q.wp] = din_i;
            fifo_d.wp = (fifo_q.wp == AW'(DEPTH - 1)) ? '0 : fifo_q.wp + 1'b1;
        end
        if (do_pop) begin
            fifo_d.rp = (fifo_q.rp == AW'(DEPTH - 1)) ? '0 : fifo_q.rp + 1'b1;
        end
        fifo_d.cnt = fifo_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign full_o   = (fifo_q.cnt == CW'(DEPTH));
    assign nempty_o = (fifo_q.cnt != '0);
    assign dout_o   = nempty_o ? fifo_q.mem[fifo_q.rp] : '0;
    assign ovf_o    = push_i && full_o;

    // R10: a dropped character leaves the queue and its head untouched
    p_ovf_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_o && !pop_i) |=> (full_o && $stable(dout_o)));

    // R9: occupancy never exceeds the depth
    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_q.cnt <= CW'(DEPTH));

endmodule

// File: rtl/rxb_flow.sv
`timescale 1ns/1ps
module rxb_flow (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ovf_i,
    input  logic full_i,
    input  logic err_clr_i,
    input  logic auto_i,
    output logic overrun_o,
    output logic rts_o
);

    typedef struct packed {
        logic ovr;
        logic rts;
    } flow_t;

    flow_t flow_d, flow_q;

    always_comb begin
        flow_d = flow_q;
        if (ovf_i) begin
            flow_d.ovr = 1'b1;
        end else if (err_clr_i) begin
            flow_d.ovr = 1'b0;
        end
        if (!auto_i) begin
            flow_d.rts = 1'b1;
        end else if (ovf_i) begin
            flow_d.rts = 1'b0;
        end else if (!full_i) begin
            flow_d.rts = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flow_q <= '{ovr: 1'b0, rts: 1'b1};
        end else begin
            flow_q <= flow_d;
        end
    end

    assign overrun_o = flow_q.ovr;
    assign rts_o     = flow_q.rts;

    // R11: overrun persists until explicitly cleared
    p_ovr_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (overrun_o && !err_clr_i) |=> overrun_o);

    // R12: automatic flow control drops request-to-send on overrun
    p_rts_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (auto_i && ovf_i) |=> !rts_o);

endmodule

// File: rtl/serial_rx_brk.sv
`timescale 1ns/1ps
module serial_rx_brk
    import rxb_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rx_i,
    input  logic        tick16_i,
    input  logic [1:0]  cfg_data_bits_i,
    input  logic [1:0]  cfg_parity_i,
    input  logic        cfg_rts_auto_i,
    input  logic        pop_i,
    input  logic        err_clr_i,
    output logic [7:0]  rd_data_o,
    output logic        err_parity_o,
    output logic        err_frame_o,
    output logic        brk_o,
    output logic        rx_ready_o,
    output logic        fifo_full_o,
    output logic        overrun_o,
    output logic        rts_o
);

    localparam int ENTRY_W = $bits(rx_entry_t);

    logic      push, ovf;
    rx_entry_t push_entry, head;

    rxb_frame #(.OVS(OVS)) u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_i       (rx_i),
        .tick_i     (tick16_i),
        .cfg_bits_i (cfg_data_bits_i),
        .cfg_par_i  (cfg_parity_i),
        .push_o     (push),
        .entry_o    (push_entry)
    );

    rxb_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (push),
        .din_i    (push_entry),
        .pop_i    (pop_i),
        .dout_o   (head),
        .nempty_o (rx_ready_o),
        .full_o   (fifo_full_o),
        .ovf_o    (ovf)
    );

    rxb_flow u_flow (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ovf_i     (ovf),
        .full_i    (fifo_full_o),
        .err_clr_i (err_clr_i),
        .auto_i    (cfg_rts_auto_i),
        .overrun_o (overrun_o),
        .rts_o     (rts_o)
    );

    assign rd_data_o    = head.data;
    assign err_parity_o = head.parity;
    assign err_frame_o  = head.frame;
    assign brk_o        = head.brk;

    // R9: head flags carry meaning only while an entry is present
    p_flags_need_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_ready_o |-> !(err_parity_o || err_frame_o || brk_o || (rd_data_o != 8'h00)));

    // R6: a break entry always reads as zero data without a framing error
    p_brk_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_ready_o && brk_o) |-> (rd_data_o == 8'h00 && !err_frame_o));

    // R9: a full queue is never reported as empty
    p_full_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_full_o |-> rx_ready_o);

endmodule

// File: tb/serial_rx_brk_bench.sv
`timescale 1ns/1ps
module serial_rx_brk_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cfg_bits = 2'b11;
    logic [1:0] cfg_par = 2'b00;
    logic       rts_auto = 1'b0;
    logic       pop = 1'b0;
    logic       err_clr = 1'b0;

    logic [7:0] rd_data;
    logic       pe, fe, brk, ready, full, ovr, rts;

    int    checks = 0;
    int    errors = 0;
    logic  mon_en = 1'b1;
    logic  [10:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    serial_rx_brk u_serial_rx_brk (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .rx_i            (rx),
        .tick16_i        (tick),
        .cfg_data_bits_i (cfg_bits),
        .cfg_parity_i    (cfg_par),
        .cfg_rts_auto_i  (rts_auto),
        .pop_i           (pop),
        .err_clr_i       (err_clr),
        .rd_data_o       (rd_data),
        .err_parity_o    (pe),
        .err_frame_o     (fe),
        .brk_o           (brk),
        .rx_ready_o      (ready),
        .fifo_full_o     (full),
        .overrun_o       (ovr),
        .rts_o           (rts)
    );

    initial begin : tick_gen
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            tick = (c == 3);
            c = (c + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick) @(posedge clk);
        end
    endtask

    task automatic put_bit(input logic v, input int n);
        @(negedge clk);
        rx = v;
        wait_ticks(n);
    endtask

    task automatic expect_entry(input string tag, input logic [7:0] d, input logic p,
                                input logic f, input logic b);
        exp_q.push_back({b, f, p, d});
        tag_q.push_back(tag);
    endtask

    task automatic send_char(input logic [7:0] d, input int nb, input logic [1:0] pm,
                             input logic stop_v, input logic flip);
        logic p;
        p = 1'b0;
        put_bit(1'b0, 16);
        for (int i = 0; i < nb; i++) begin
            put_bit(d[i], 16);
            p = p ^ d[i];
        end
        if (pm == 2'b01 || pm == 2'b10) begin
            if (pm == 2'b10) p = ~p;
            put_bit(p ^ flip, 16);
        end
        put_bit(stop_v, 16);
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    // scoreboard monitor: compare each head entry with the oldest expected item
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_en && ready) begin
                logic [10:0] got;
                logic [10:0] e;
                string       t;
                got = {brk, fe, pe, rd_data};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected entry", got, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(got == e, t, got, e);
                end
                pop = 1'b1;
                @(negedge clk);
                pop = 1'b0;
            end
        end
    end

    initial begin : watchdog
        #(4 * 150000);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!ready, "R9 reset ready", ready, 0);
        chk(!full, "R9 reset full", full, 0);
        chk(!ovr, "R11 reset overrun", ovr, 0);
        chk(rts, "R12 reset rts with auto off", rts, 1);
        rst_n = 1'b1;
        put_bit(1'b1, 32);

        // R2 R4: 8N1, back-to-back frames with no idle gap
        expect_entry("R4 first of back-to-back", 8'hA5, 0, 0, 0);
        expect_entry("R4 second of back-to-back", 8'h3C, 0, 0, 0);
        send_char(8'hA5, 8, 2'b00, 1'b1, 1'b0);
        send_char(8'h3C, 8, 2'b00, 1'b1, 1'b0);
        put_bit(1'b1, 32);
        drain("R4 drain");

        // R3: 7 data bits even parity, good and bad
        cfg_bits = 2'b10; cfg_par = 2'b01;
        expect_entry("R3 even parity good", 8'h5A, 0, 0, 0);
        expect_entry("R3 even parity bad", 8'h11, 1, 0, 0);
        send_char(8'h5A, 7, 2'b01, 1'b1, 1'b0);
        send_char(8'h11, 7, 2'b01, 1'b1, 1'b1);
        put_bit(1'b1, 32);
        drain("R3 even drain");

        // R3: 8 data bits odd parity, good and bad
        cfg_bits = 2'b11; cfg_par = 2'b10;
        expect_entry("R3 odd parity good", 8'h00, 0, 0, 0);
        expect_entry("R3 odd parity bad", 8'h80, 1, 0, 0);
        send_char(8'h00, 8, 2'b10, 1'b1, 1'b0);
        send_char(8'h80, 8, 2'b10, 1'b1, 1'b1);
        put_bit(1'b1, 32);
        drain("R3 odd drain");

        // R2: 5 and 6 data bits, no parity, right-aligned
        cfg_bits = 2'b00; cfg_par = 2'b00;
        expect_entry("R2 five bits", 8'h15, 0, 0, 0);
        send_char(8'h15, 5, 2'b00, 1'b1, 1'b0);
        cfg_bits = 2'b01; cfg_par = 2'b11;
        expect_entry("R2 six bits reserved parity", 8'h2B, 0, 0, 0);
        send_char(8'h2B, 6, 2'b00, 1'b1, 1'b0);
        put_bit(1'b1, 32);
        drain("R2 drain");

        // R1: a 3-tick low glitch must not start a frame
        cfg_bits = 2'b11; cfg_par = 2'b00;
        put_bit(1'b0, 3);
        put_bit(1'b1, 64);
        chk(!ready, "R1 glitch rejected", ready, 0);

        // R5: nonzero frame with low stop, line stays low -> new frame recovered
        expect_entry("R5 framing error char", 8'h55, 0, 1, 0);
        expect_entry("R5 recovered next char", 8'hA3, 0, 0, 0);
        send_char(8'h55, 8, 2'b00, 1'b0, 1'b0);
        send_char(8'hA3, 8, 2'b00, 1'b1, 1'b0);
        put_bit(1'b1, 32);
        drain("R5 drain");

        // R6 R7: full break, then a short high pulse and more low adds nothing
        expect_entry("R6 break entry", 8'h00, 0, 0, 1);
        put_bit(1'b0, 16 * 14);
        put_bit(1'b1, 3);
        put_bit(1'b0, 16 * 12);
        put_bit(1'b1, 48);
        drain("R7 drain");
        chk(!ready, "R7 no extra entry after short high", ready, 0);

        // R8: break starting at data bit 4 of 0xFF
        expect_entry("R8 damaged char", 8'h0F, 0, 1, 0);
        expect_entry("R8 following break", 8'h00, 0, 0, 1);
        put_bit(1'b0, 16);
        for (int i = 0; i < 4; i++) put_bit(1'b1, 16);
        put_bit(1'b0, 16 * 24);
        put_bit(1'b1, 48);
        drain("R8 drain");

        // R10 R11 R12: overflow the queue with auto flow control on
        mon_en = 1'b0;
        rts_auto = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            send_char(8'(k * 8'h11), 8, 2'b00, 1'b1, 1'b0);
        end
        put_bit(1'b1, 16);
        chk(full, "R9 full after four", full, 1);
        chk(ovr, "R10 overrun set", ovr, 1);
        chk(!rts, "R12 rts dropped", rts, 0);
        chk(rd_data == 8'h11, "R10 oldest kept", rd_data, 8'h11);
        @(negedge clk); pop = 1'b1;
        @(negedge clk); pop = 1'b0;
        repeat (2) @(negedge clk);
        chk(rts, "R12 rts restored", rts, 1);
        chk(ovr, "R11 overrun survives pop", ovr, 1);
        chk(!full, "R9 not full after pop", full, 0);
        chk(rd_data == 8'h22, "R10 second kept", rd_data, 8'h22);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
        chk(!ovr, "R11 overrun cleared", ovr, 0);
        expect_entry("R10 remaining 22", 8'h22, 0, 0, 0);
        expect_entry("R10 remaining 33", 8'h33, 0, 0, 0);
        expect_entry("R10 remaining 44", 8'h44, 0, 0, 0);
        mon_en = 1'b1;
        drain("R10 drain");
        chk(!ready, "R10 fifth char discarded", ready, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule